// File: doc/BRIEF.md
# External Interrupt Sensitivity Controller

This block turns an active-low interrupt pin and a set of wake-up pins into a single interrupt request for a processor core. The wake-up pins are individually enabled. Each enabled wake-up pin is ORed with the inverted interrupt pin to form one combined event signal. A 2-bit sensitivity code decides whether the request fires on a rising edge and high level of that combined signal, on its rising edge only, on its falling edge only, or on both edges. Seen from the interrupt pin, those four modes are falling edge and low level, falling edge, rising edge, and either edge.

An 8-bit control register holds the sensitivity code and a global enable. It can be written only while the core's interrupt mask is set, and a write made while the mask is clear is ignored. When a write selects a different sensitivity code, any pending request is dropped. An acknowledge strobe clears a pending request that came from an edge.

Because all sources share one signal, a wake-up pin held high hides every event on the other sources until it returns low.

Top module: `ext_irq_sense`

## Requirements
- R1: The combined signal is `~irq_n_pin | OR(wake_pin & wake_en)`. A wake-up pin whose enable is 0 never causes a request.
- R2: While an enabled wake-up pin is high, edges and levels on the interrupt pin or on other wake-up pins cause no request.
- R3: Code 2'b00 sets the request on a rising edge of the combined signal. The request also stays high, even after an acknowledge, for as long as the combined signal is high.
- R4: Code 2'b01 latches a request only on a rising edge of the combined signal (interrupt pin falling, wake-up pin rising). The request holds until acknowledged.
- R5: Code 2'b10 latches a request only on a falling edge of the combined signal (interrupt pin rising, wake-up pin falling).
- R6: Code 2'b11 latches a request on either edge of the combined signal.
- R7: A register write takes effect only when `imask` is 1 during `cfg_we`. Otherwise the register keeps its value.
- R8: When the enable bit is 0, `int_req` stays low whatever the inputs do.
- R9: After reset, `cfg_rdata` reads 8'h20 (code 2'b00, enable 1) and `int_req` is 0.
- R10: An accepted write that changes the code clears a pending request. A write of the same code leaves it in place.
- R11: Readback places the code in bits 7:6 and the enable in bit 5. Bits 4:0 read as 0, whatever was written.
- R12: A pin change is seen after a 2-flop synchronizer. An edge request appears at the third rising clock edge after the pin changes. An acknowledge drops it at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n_pin | input | 1 | Active-low interrupt pin, asynchronous |
| wake_pin | input | N_WAKE | Wake-up pins, asynchronous |
| wake_en | input | N_WAKE | Per-pin wake-up enable |
| imask | input | 1 | Core interrupt mask; 1 permits register writes |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| int_ack | input | 1 | Interrupt acknowledge strobe |
| int_req | output | 1 | Interrupt request to the core |
| cfg_rdata | output | 8 | Register readback |

## Verification
The assertions assume that `int_ack` does not coincide with a register write. They also assume that the request's level term, not the pending flag, is the only thing that can hold `int_req` high in code 2'b00. The bench keeps to this by placing every acknowledge in a cycle of its own. It changes pins only after the previous event has settled through the synchronizer. A sweep covers every sensitivity code against every source in both directions, and each expected request is computed from a table of rising, falling and level rules per code.

// File: rtl/eis_pkg.sv
package eis_pkg;
   localparam int REG_W   = 8;
   localparam int CODE_HI = 7;
   localparam int CODE_LO = 6;
   localparam int EN_BIT  = 5;

   typedef enum logic [1:0] {
      SENSE_LVL_RISE = 2'b00,
      SENSE_RISE     = 2'b01,
      SENSE_FALL     = 2'b10,
      SENSE_BOTH     = 2'b11
   } sense_e;

   typedef struct packed {
      sense_e sense;
      logic   en;
   } cfg_t;

   localparam cfg_t CFG_RESET = '{sense: SENSE_LVL_RISE, en: 1'b1};
endpackage

// File: rtl/eis_sync.sv
module eis_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/eis_combine.sv
module eis_combine #(
   parameter int N = 4
) (
   input  logic         irq_n,
   input  logic [N-1:0] wake,
   input  logic [N-1:0] wake_en,
   output logic         ei
);
   logic [N-1:0] gated;
   assign gated = wake & wake_en;
   assign ei    = ~irq_n | (|gated);
endmodule

// File: rtl/eis_cfg.sv
module eis_cfg
   import eis_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we,
   input  logic       imask,
   input  logic [2:0] wbits,
   output cfg_t       cfg,
   output logic       sense_chg
);
   logic   take;
   sense_e new_sense;

   assign take      = we & imask;
   assign new_sense = sense_e'(wbits[2:1]);
   assign sense_chg = take & (new_sense != cfg.sense);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cfg <= CFG_RESET;
      else if (take) cfg <= '{sense: new_sense, en: wbits[0]};
   end
endmodule

// File: rtl/eis_detect.sv
module eis_detect
   import eis_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ei,
   input  cfg_t cfg,
   input  logic clr,
   input  logic ack,
   output logic edge_hit,
   output logic req
);
   logic ei_q;
   logic pend;

   always_comb begin
      unique case (cfg.sense)
         SENSE_LVL_RISE,
         SENSE_RISE:     edge_hit = ei & ~ei_q;
         SENSE_FALL:     edge_hit = ~ei & ei_q;
         default:        edge_hit = ei ^ ei_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ei_q <= 1'b0;
         pend <= 1'b0;
      end else begin
         ei_q <= ei;
         if (clr || !cfg.en) pend <= 1'b0;
         else if (edge_hit)  pend <= 1'b1;
         else if (ack)       pend <= 1'b0;
      end
   end

   assign req = cfg.en & (pend | ((cfg.sense == SENSE_LVL_RISE) & ei));
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
   import eis_pkg::*;
#(
   parameter int N_WAKE      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_n_pin,
   input  logic [N_WAKE-1:0] wake_pin,
   input  logic [N_WAKE-1:0] wake_en,
   input  logic              imask,
   input  logic              cfg_we,
   input  logic [REG_W-1:0]  cfg_wdata,
   input  logic              int_ack,
   output logic              int_req,
   output logic [REG_W-1:0]  cfg_rdata
);
   generate
      if (N_WAKE < 1 || N_WAKE > 32) begin : g_bad_nwake
         $error("N_WAKE must lie in 1..32");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic              irq_n_s;
   logic [N_WAKE-1:0] wake_s;
   logic              ei;
   cfg_t              cfg;
   logic              sense_chg;
   logic              edge_hit;
   logic              unused_wdata;

   assign unused_wdata = ^cfg_wdata[EN_BIT-1:0];

   eis_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_irq (
      .clk(clk), .rst_n(rst_n), .d(irq_n_pin), .q(irq_n_s));

   eis_sync #(.W(N_WAKE), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_wake (
      .clk(clk), .rst_n(rst_n), .d(wake_pin), .q(wake_s));

   eis_combine #(.N(N_WAKE)) u_comb (
      .irq_n(irq_n_s), .wake(wake_s), .wake_en(wake_en), .ei(ei));

   eis_cfg u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .imask(imask),
      .wbits(cfg_wdata[CODE_HI:EN_BIT]), .cfg(cfg), .sense_chg(sense_chg));

   eis_detect u_det (
      .clk(clk), .rst_n(rst_n), .ei(ei), .cfg(cfg), .clr(sense_chg),
      .ack(int_ack), .edge_hit(edge_hit), .req(int_req));

   always_comb begin
      cfg_rdata                 = '0;
      cfg_rdata[CODE_HI:CODE_LO] = cfg.sense;
      cfg_rdata[EN_BIT]          = cfg.en;
   end
endmodule

// File: rtl/eis_checker.sv
module eis_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       cfg_we,
   input logic       imask,
   input logic [7:0] cfg_wdata,
   input logic [7:0] cfg_rdata,
   input logic       int_ack,
   input logic       int_req,
   input logic       edge_hit
);
   // R7
   ign_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !imask) |=> $stable(cfg_rdata));

   // R7
   take_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && imask) |=> (cfg_rdata[7:5] == $past(cfg_wdata[7:5])));

   // R11
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[4:0] == 5'b0);

   // R8
   dis_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rdata[5] |-> !int_req);

   // R10
   chg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && imask && cfg_wdata[7:6] != cfg_rdata[7:6] && cfg_wdata[7:6] != 2'b00)
      |=> !int_req);

   // R4
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int_ack && !edge_hit && !cfg_we && cfg_rdata[7:6] != 2'b00) |=> !int_req);
endmodule

bind ext_irq_sense eis_checker u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .imask(imask),
   .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .int_ack(int_ack),
   .int_req(int_req), .edge_hit(edge_hit));

// File: tb/tb_ext_irq_sense.sv
module tb_ext_irq_sense;
   localparam int NW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          irq_n_pin = 1'b1;
   logic [NW-1:0] wake_pin = '0;
   logic [NW-1:0] wake_en = '1;
   logic          imask = 1'b1;
   logic          cfg_we = 1'b0;
   logic [7:0]    cfg_wdata = '0;
   logic          int_ack = 1'b0;
   logic          int_req;
   logic [7:0]    cfg_rdata;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   always #5 clk = ~clk;

   ext_irq_sense #(.N_WAKE(NW), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .irq_n_pin(irq_n_pin), .wake_pin(wake_pin),
      .wake_en(wake_en), .imask(imask), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .int_ack(int_ack), .int_req(int_req), .cfg_rdata(cfg_rdata));

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk1(input logic got, input logic exp, input string tag, input string what);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %b expected %b", tag, what, got, exp);
      end
   endtask

   task automatic chk8(input logic [7:0] got, input logic [7:0] exp, input string tag, input string what);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] d, input logic im);
      @(negedge clk);
      cfg_wdata = d; cfg_we = 1'b1; imask = im;
      @(negedge clk);
      cfg_we = 1'b0; imask = 1'b1;
   endtask

   task automatic ack1();
      @(negedge clk);
      int_ack = 1'b1;
      @(negedge clk);
      int_ack = 1'b0;
   endtask

   task automatic set_src(input int s, input logic act);
      if (s == NW) irq_n_pin = ~act;
      else         wake_pin[s] = act;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got hang expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R9 reset state
      chk8(cfg_rdata, 8'h20, "R9", "reset readback");
      chk1(int_req, 1'b0, "R9", "reset request");

      // R7 masked-off write ignored
      wr(8'hC0, 1'b0);
      chk8(cfg_rdata, 8'h20, "R7", "write with mask clear");
      // R11 low bits dropped
      wr(8'hDF, 1'b1);
      chk8(cfg_rdata, 8'hC0, "R11", "readback layout");

      // sweep: every code x every source x both directions (R3 R4 R5 R6)
      for (int code = 0; code < 4; code++) begin
         logic rise_exp, fall_exp, lvl_exp;
         rise_exp = (code != 2);
         fall_exp = (code >= 2);
         lvl_exp  = (code == 0);
         wr({code[1:0], 1'b1, 5'b0}, 1'b1);
         tick(4); ack1(); tick(1);
         chk8(cfg_rdata, {code[1:0], 1'b1, 5'b0}, "R11", "code readback");
         for (int s = 0; s <= NW; s++) begin
            set_src(s, 1'b1);
            tick(4);
            chk1(int_req, rise_exp, "R4", $sformatf("rise code %0d src %0d", code, s));
            tick(3);
            chk1(int_req, rise_exp, "R6", $sformatf("held code %0d src %0d", code, s));
            ack1(); tick(1);
            chk1(int_req, lvl_exp, "R3", $sformatf("after ack code %0d src %0d", code, s));
            set_src(s, 1'b0);
            tick(4);
            chk1(int_req, fall_exp, "R5", $sformatf("fall code %0d src %0d", code, s));
            ack1(); tick(1);
            chk1(int_req, 1'b0, "R6", $sformatf("idle code %0d src %0d", code, s));
         end
      end

      // R1 disabled wake pins have no effect
      wr(8'hE0, 1'b1);
      tick(2);
      for (int p = 0; p < NW; p++) begin
         wake_en = ~(NW'(1) << p);
         wake_pin[p] = 1'b1; tick(4);
         chk1(int_req, 1'b0, "R1", $sformatf("disabled pin %0d high", p));
         wake_pin[p] = 1'b0; tick(4);
         chk1(int_req, 1'b0, "R1", $sformatf("disabled pin %0d low", p));
      end
      wake_en = '1;

      // R2 high wake pin masks interrupt pin
      wake_pin[0] = 1'b1; tick(4); ack1(); tick(1);
      irq_n_pin = 1'b0; tick(4);
      chk1(int_req, 1'b0, "R2", "irq fall masked");
      irq_n_pin = 1'b1; tick(4);
      chk1(int_req, 1'b0, "R2", "irq rise masked");
      wake_pin[1] = 1'b1; tick(4);
      chk1(int_req, 1'b0, "R2", "second wake masked");
      wake_pin[1] = 1'b0; wake_pin[0] = 1'b0; tick(4);
      chk1(int_req, 1'b1, "R6", "release edge");
      ack1(); tick(1);

      // R12 latency with code 01
      wr(8'h60, 1'b1); tick(2);
      irq_n_pin = 1'b0;
      tick(1); chk1(int_req, 1'b0, "R12", "latency edge 1");
      tick(1); chk1(int_req, 1'b0, "R12", "latency edge 2");
      tick(1); chk1(int_req, 1'b1, "R12", "latency edge 3");
      ack1();
      chk1(int_req, 1'b0, "R12", "ack next edge");
      irq_n_pin = 1'b1; tick(4);

      // R8 disabled: even level mode stays low
      wr(8'h00, 1'b1);
      irq_n_pin = 1'b0; tick(4);
      chk1(int_req, 1'b0, "R8", "disabled level");
      irq_n_pin = 1'b1; tick(4);

      // R10 code change clears pending, same code keeps it
      wr(8'h60, 1'b1); tick(2);
      irq_n_pin = 1'b0; tick(4);
      chk1(int_req, 1'b1, "R10", "pending set");
      wr(8'h60, 1'b1);
      chk1(int_req, 1'b1, "R10", "same code keeps");
      wr(8'h60, 1'b0);
      wr(8'hA0, 1'b0);
      chk1(int_req, 1'b1, "R7", "ignored write keeps pending");
      wr(8'hA0, 1'b1);
      chk1(int_req, 1'b0, "R10", "changed code clears");
      irq_n_pin = 1'b1; tick(4);
      chk1(int_req, 1'b1, "R5", "fall mode after change");
      ack1(); tick(1);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule